// File: doc/BRIEF.md
# Interrupt Pending and Active Tracker

This block holds the interrupt state for a group of request lines. Each line has a pending flag and an active flag. A request from a peripheral sets the pending flag, and the flag stays set after the peripheral lets go of its line. The request is therefore served even when the source only pulses. Software can set or clear any pending flag through a narrow write port that carries a line index and an operation.

The processor core acknowledges a line with a strobe and an index when it enters the handler for that line. It reports the end of the handler with a return strobe and an index. Each line can capture requests in edge mode or in level mode, and each line has its own enable. The block drives a vector of lines that are pending, enabled and not active. A separate priority arbiter consumes that vector.

The pending and active flags are independent. A line can therefore pend again while its own handler runs, and it can pend while it is disabled. A global input clears every active flag at once, so the system can recover after an error.

Top module: `irq_state_tracker`

## Requirements
- R1: A rising edge on `req_i[n]` in edge mode sets `pending_o[n]` at the second clock edge after the input rises. The flag stays set after the input falls.
- R2: Several pulses on a line before it is acknowledged produce one pending request. After one acknowledge and one return, the line is neither pending nor active.
- R3: An acknowledge (`ack_i` with `ack_idx_i` = n) clears `pending_o[n]` and sets `active_o[n]` at the same clock edge.
- R4: `offer_o[n]` is high exactly when line n is pending, enabled and not active. An active line stays off the offer vector until a return for that line clears `active_o[n]`.
- R5: If the line's captured request is still high when its return is taken, `pending_o[n]` sets at the same edge that clears `active_o[n]`.
- R6: A new pulse that arrives during the line's own handler, after the request has dropped, sets `pending_o[n]` again. The line is offered once its return is taken.
- R7: A line becomes pending while `enable_i[n]` is 0. It appears on `offer_o` in the same cycle that its enable goes to 1.
- R8: A write with `sw_valid_i` = 1 uses `sw_op_i` = 1 to set `pending_o[sw_idx_i]` and `sw_op_i` = 0 to clear it, at the next edge. A clear before the acknowledge cancels the request. A hardware request event in the same cycle wins over a software clear.
- R9: If a software set and an acknowledge hit the same line in the same cycle, the acknowledge wins. The pending flag reads 0 after that edge, and the set takes effect one edge later.
- R10: `clr_active_i` = 1 clears all active flags at the next edge.
- R11: In level mode (`level_mode_i[n]` = 1), a line that is not active re-pends every cycle while its captured request is high, so a software clear does not hold. In edge mode, a request held high raises only one pending event until the next return.
- R12: After reset, all pending, active and offer outputs are 0.
- R13: A write, acknowledge or return whose index is NUM_LINES or larger has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | NUM_LINES | Request lines from the sources |
| level_mode_i | input | NUM_LINES | Per-line capture mode: 1 level, 0 edge |
| enable_i | input | NUM_LINES | Per-line enable for the offer vector |
| sw_valid_i | input | 1 | Software write strobe |
| sw_op_i | input | 1 | Software operation: 1 set pending, 0 clear pending |
| sw_idx_i | input | IDX_W | Line index of the software write |
| ack_i | input | 1 | Acknowledge strobe from the core on handler entry |
| ack_idx_i | input | IDX_W | Line index of the acknowledge |
| ret_i | input | 1 | Return strobe from the core on handler exit |
| ret_idx_i | input | IDX_W | Line index of the return |
| clr_active_i | input | 1 | Clears all active flags |
| pending_o | output | NUM_LINES | Pending flags |
| active_o | output | NUM_LINES | Active flags |
| offer_o | output | NUM_LINES | Lines that are pending, enabled and not active, sent to the arbiter |

## Verification
The bench sweeps each line through a full life cycle: burst pulses, acknowledge, a pulse during the handler, return and a second service. A design that counted pulses would leave a stale request behind. A design that mixed the active and pending flags would lose the re-pend that happens inside the handler. Separate cases cover a request held across the return, an acknowledge that collides with a software set, a software clear that meets a fresh edge, and level capture against a software clear. A wrong priority in any of these cases would lose a request or create an extra one. Indices beyond the last line and the global clear of active flags are also tested. An incomplete index decode would corrupt a real line in those cases.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;

  typedef enum logic {
    SW_CLEAR = 1'b0,
    SW_SET   = 1'b1
  } sw_op_e;

endpackage

// File: rtl/irq_req_capture.sv
// Registers the raw request lines once and flags a rising edge of the
// registered copy, so a held request yields a single event.
module irq_req_capture #(
  parameter int NUM_LINES = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] req_i,
  output logic [NUM_LINES-1:0] req_q_o,
  output logic [NUM_LINES-1:0] rise_o
);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic cur_q;
    logic prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cur_q  <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        cur_q  <= req_i[g];
        prev_q <= cur_q;
      end
    end

    assign req_q_o[g] = cur_q;
    assign rise_o[g]  = cur_q & ~prev_q;
  end

endmodule

// File: rtl/irq_cmd_decode.sv
// Turns the indexed software, acknowledge and return strobes into per-line
// vectors and defers a software set that collides with an acknowledge.
module irq_cmd_decode
  import irq_trk_pkg::*;
#(
  parameter int NUM_LINES = 6,
  parameter int IDX_W     = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sw_valid_i,
  input  logic                 sw_op_i,
  input  logic [IDX_W-1:0]     sw_idx_i,
  input  logic                 ack_i,
  input  logic [IDX_W-1:0]     ack_idx_i,
  input  logic                 ret_i,
  input  logic [IDX_W-1:0]     ret_idx_i,
  output logic [NUM_LINES-1:0] sw_set_o,
  output logic [NUM_LINES-1:0] sw_clr_o,
  output logic [NUM_LINES-1:0] ack_vec_o,
  output logic [NUM_LINES-1:0] ret_vec_o
);

  logic [NUM_LINES-1:0] sw_hit;
  logic [NUM_LINES-1:0] set_raw;
  logic [NUM_LINES-1:0] defer_d;
  logic [NUM_LINES-1:0] defer_q;
  logic                 defer_en;
  sw_op_e               op;

  assign op = sw_op_e'(sw_op_i);

  always_comb begin
    for (int k = 0; k < NUM_LINES; k++) begin
      sw_hit[k]    = sw_valid_i && (sw_idx_i  == IDX_W'(k));
      ack_vec_o[k] = ack_i      && (ack_idx_i == IDX_W'(k));
      ret_vec_o[k] = ret_i      && (ret_idx_i == IDX_W'(k));
    end
  end

  always_comb begin
    set_raw  = (op == SW_SET)   ? sw_hit : '0;
    sw_clr_o = (op == SW_CLEAR) ? sw_hit : '0;
    defer_d  = set_raw & ack_vec_o;
    sw_set_o = (set_raw & ~ack_vec_o) | defer_q;
    defer_en = (defer_d != defer_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      defer_q <= '0;
    end else if (defer_en) begin
      defer_q <= defer_d;
    end
  end

  p_defer_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_raw & ack_vec_o) != '0 |=> (sw_set_o & $past(set_raw)) != '0);

endmodule

// File: rtl/irq_line_state.sv
// Pending and active flags of one line.
module irq_line_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_q_i,
  input  logic rise_i,
  input  logic level_mode_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  input  logic ack_i,
  input  logic ret_i,
  input  logic clr_all_i,
  output logic pend_o,
  output logic act_o
);

  logic pend_q, pend_d, pend_en;
  logic act_q, act_d, act_en;
  logic ret_hit, lvl_set, hw_set;

  always_comb begin
    ret_hit = ret_i & act_q;
    lvl_set = level_mode_i & req_q_i & ~act_q & ~ack_i;
    hw_set  = rise_i | lvl_set | (ret_hit & req_q_i);
    pend_d  = (pend_q & ~ack_i & ~sw_clr_i) | hw_set | sw_set_i;
    act_d   = clr_all_i ? 1'b0 : ((act_q & ~ret_hit) | ack_i);
    pend_en = (pend_d != pend_q);
    act_en  = (act_d != act_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
    end else if (act_en) begin
      act_q <= act_d;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;

  p_hold_pend_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !ack_i && !sw_clr_i |=> pend_q);

  p_ack_active_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !clr_all_i |=> act_q);

  p_ret_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i && act_q && !ack_i && !clr_all_i |=> !act_q);

  p_ret_repend_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i && act_q && req_q_i |=> pend_q);

endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker #(
  parameter int NUM_LINES = 6,
  parameter int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic [NUM_LINES-1:0] level_mode_i,
  input  logic [NUM_LINES-1:0] enable_i,
  input  logic                 sw_valid_i,
  input  logic                 sw_op_i,
  input  logic [IDX_W-1:0]     sw_idx_i,
  input  logic                 ack_i,
  input  logic [IDX_W-1:0]     ack_idx_i,
  input  logic                 ret_i,
  input  logic [IDX_W-1:0]     ret_idx_i,
  input  logic                 clr_active_i,
  output logic [NUM_LINES-1:0] pending_o,
  output logic [NUM_LINES-1:0] active_o,
  output logic [NUM_LINES-1:0] offer_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n = rst_sync_q[1];

  logic [NUM_LINES-1:0] req_q, rise;
  logic [NUM_LINES-1:0] sw_set, sw_clr, ack_vec, ret_vec;

  irq_req_capture #(.NUM_LINES(NUM_LINES)) i_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .req_i   (req_i),
    .req_q_o (req_q),
    .rise_o  (rise)
  );

  irq_cmd_decode #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) i_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .sw_valid_i (sw_valid_i),
    .sw_op_i    (sw_op_i),
    .sw_idx_i   (sw_idx_i),
    .ack_i      (ack_i),
    .ack_idx_i  (ack_idx_i),
    .ret_i      (ret_i),
    .ret_idx_i  (ret_idx_i),
    .sw_set_o   (sw_set),
    .sw_clr_o   (sw_clr),
    .ack_vec_o  (ack_vec),
    .ret_vec_o  (ret_vec)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_state
    irq_line_state i_line (
      .clk_i        (clk_i),
      .rst_ni       (rst_n),
      .req_q_i      (req_q[g]),
      .rise_i       (rise[g]),
      .level_mode_i (level_mode_i[g]),
      .sw_set_i     (sw_set[g]),
      .sw_clr_i     (sw_clr[g]),
      .ack_i        (ack_vec[g]),
      .ret_i        (ret_vec[g]),
      .clr_all_i    (clr_active_i),
      .pend_o       (pending_o[g]),
      .act_o        (active_o[g])
    );
  end

  assign offer_o = pending_o & enable_i & ~active_o;

  p_clr_active_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    clr_active_i |=> active_o == '0);

  p_ack_drops_offer_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    ack_i && !clr_active_i && (32'(ack_idx_i) < NUM_LINES)
      |=> (offer_o & active_o) == '0 && active_o != '0);

endmodule

// File: tb/test_irq_state_tracker.sv
module test_irq_state_tracker;
  localparam int  N      = 6;
  localparam int  IW     = 3;
  localparam time PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0, lvl = '0, en = '1;
  logic          sw_valid = 1'b0, sw_op = 1'b0;
  logic [IW-1:0] sw_idx = '0, ack_idx = '0, ret_idx = '0;
  logic          ack = 1'b0, ret = 1'b0, clr_act = 1'b0;
  logic [N-1:0]  pend, act, offer;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  irq_state_tracker #(.NUM_LINES(N)) i_irq_state_tracker (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .level_mode_i(lvl), .enable_i(en),
    .sw_valid_i(sw_valid), .sw_op_i(sw_op), .sw_idx_i(sw_idx),
    .ack_i(ack), .ack_idx_i(ack_idx), .ret_i(ret), .ret_idx_i(ret_idx),
    .clr_active_i(clr_act), .pending_o(pend), .active_o(act), .offer_o(offer)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic pulse(int i);
    req[i] = 1'b1; tick();
    req[i] = 1'b0; tick();
  endtask

  task automatic do_ack(int i);
    ack = 1'b1; ack_idx = IW'(i); tick(); ack = 1'b0;
  endtask

  task automatic do_ret(int i);
    ret = 1'b1; ret_idx = IW'(i); tick(); ret = 1'b0;
  endtask

  task automatic do_sw(bit op, int i);
    sw_valid = 1'b1; sw_op = op; sw_idx = IW'(i); tick(); sw_valid = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    tick(); tick(); tick();
    chk("R12 pending", pend, '0);
    chk("R12 active", act, '0);
    chk("R12 offer", offer, '0);

    // Life cycle of every line in edge mode
    for (int i = 0; i < N; i++) begin
      logic [N-1:0] b;
      b = N'(1) << i;
      pulse(i); pulse(i); pulse(i);
      chk("R1 R2 pend after burst", pend, b);
      chk("R4 offer pending line", offer, b);
      do_ack(i);
      chk("R3 pend cleared", pend, '0);
      chk("R3 active set", act, b);
      chk("R4 active not offered", offer, '0);
      pulse(i);
      chk("R6 re-pend in handler", pend, b);
      chk("R4 still not offered", offer, '0);
      do_ret(i);
      chk("R6 active cleared", act, '0);
      chk("R6 offered after return", offer, b);
      do_ack(i); do_ret(i);
      chk("R2 no extra pend", pend, '0);
      chk("R2 no active", act, '0);
    end

    // Held request across return
    req[2] = 1'b1; tick(); tick();
    chk("R1 held pend", pend, 6'b000100);
    do_ack(2);
    chk("R3 held ack active", act, 6'b000100);
    tick(); tick();
    chk("R11 edge held no repend", pend, '0);
    do_ret(2);
    chk("R5 repend at return", pend, 6'b000100);
    chk("R5 active cleared", act, '0);
    do_ack(2); req[2] = 1'b0; tick(); do_ret(2);
    chk("R5 cleanup pend", pend, '0);
    chk("R5 cleanup act", act, '0);

    // Pend while disabled
    en = 6'b110111;
    pulse(3);
    chk("R7 pend while disabled", pend, 6'b001000);
    chk("R7 not offered", offer, '0);
    en = '1; #1;
    chk("R7 offered on enable", offer, 6'b001000);
    do_sw(1'b0, 3);
    chk("R8 clear cancels", pend, '0);

    // Software set and clear sweep
    for (int i = 0; i < N; i++) begin
      do_sw(1'b1, i);
      chk("R8 sw set", pend, N'(1) << i);
      do_sw(1'b0, i);
      chk("R8 sw clear", pend, '0);
    end
    req[4] = 1'b1; tick();
    do_sw(1'b0, 4);
    chk("R8 edge beats clear", pend, 6'b010000);
    req[4] = 1'b0; tick();
    do_sw(1'b0, 4);
    chk("R8 clear after edge", pend, '0);

    // Software set colliding with acknowledge
    do_sw(1'b1, 1);
    chk("R9 pre set", pend, 6'b000010);
    sw_valid = 1'b1; sw_op = 1'b1; sw_idx = 3'd1;
    ack = 1'b1; ack_idx = 3'd1;
    tick();
    sw_valid = 1'b0; ack = 1'b0;
    chk("R9 ack wins pend", pend, '0);
    chk("R9 ack wins act", act, 6'b000010);
    tick();
    chk("R9 deferred set", pend, 6'b000010);
    do_ret(1);
    chk("R9 offered after return", offer, 6'b000010);
    do_ack(1); do_ret(1);
    chk("R9 cleanup", pend | act, '0);

    // Global clear of active flags
    do_ack(0); do_ack(1); do_ack(4);
    chk("R10 actives set", act, 6'b010011);
    clr_act = 1'b1; tick(); clr_act = 1'b0;
    chk("R10 all cleared", act, '0);

    // Level mode
    lvl = 6'b100000;
    req[5] = 1'b1; tick(); tick();
    chk("R11 level pend", pend, 6'b100000);
    do_sw(1'b0, 5);
    chk("R11 level beats clear", pend, 6'b100000);
    do_ack(5);
    chk("R11 level ack pend", pend, '0);
    tick();
    chk("R11 level masked while active", pend, '0);
    req[5] = 1'b0; tick(); do_ret(5);
    chk("R11 level cleanup", pend | act, '0);
    lvl = '0;

    req[0] = 1'b1; tick(); tick();
    chk("R11 edge held pend", pend, 6'b000001);
    do_sw(1'b0, 0);
    tick(); tick();
    chk("R11 edge held stays cleared", pend, '0);
    req[0] = 1'b0; tick();

    // Out of range indices
    do_sw(1'b1, 6); do_sw(1'b1, 7);
    chk("R13 sw out of range", pend, '0);
    do_ack(7); do_ret(6);
    chk("R13 ack out of range", act, '0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule